// File: doc/BRIEF.md
# Dual-Issue Integer Pairing Checker

This block sits in the first decode stage of an in-order integer core that has two execution pipes. The primary pipe, "u", can run any instruction. The secondary pipe, "v", can only run the instruction that follows the u-pipe one in program order. The block looks at pre-decoded descriptors for the two oldest instructions in the decode window. Each descriptor carries these fields:

- a valid bit;
- flags for simple form, control transfer and prefix;
- flags for displacement present and immediate present;
- a destination register and two source registers.

From these the block decides whether both instructions can issue in the same cycle or whether the older one issues alone.

The decision is combinational. It is captured into a small issue register toward the next stage whenever that stage signals ready. The register drives a valid bit for each pipe and a count (0, 1 or 2) of descriptors consumed from the window. When ready is low the register holds its value. A stall therefore holds the u and v slots together, and a pair stays in lockstep.

Top module: `dual_issue_pair_check`

## Requirements
- R1: While `rst` is high at a clock edge, `u_valid`, `v_valid` and `consumed` are 0 after that edge.
- R2: A pair is formed only when both `a_simple` and `b_simple` are 1.
- R3: When `a_jump` is 1, the two instructions are not paired.
- R4: When `a_dst` is nonzero and equals `b_src0` or `b_src1`, the two instructions are not paired (read-after-write).
- R5: When `a_dst` is nonzero and equals `b_dst`, the two instructions are not paired (write-after-write).
- R6: When either instruction has both its displacement flag and its immediate flag set, the two instructions are not paired.
- R7: A prefixed younger instruction (`b_prefix`=1) blocks pairing. A prefix on the older instruction alone does not block pairing.
- R8: A register field of value 0 means "no register" and never produces a RAW or WAW match.
- R9: If `b_valid` is 0, only the older instruction issues. If `a_valid` is 0, nothing issues and `consumed` is 0.
- R10: `v_valid` is 1 only together with `u_valid`. `consumed` equals 2 for a pair, 1 for a single issue and 0 when `u_valid` is 0.
- R11: While `out_ready` is 0, `u_valid`, `v_valid` and `consumed` keep their values.
- R12: On an edge with `out_ready`=1 and `rst`=0, the outputs take the decision for the inputs present before that edge: `u_valid`=`a_valid` and `v_valid`=pairing result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Older descriptor present |
| a_simple | input | 1 | Older instruction is hardwired single-cycle form |
| a_jump | input | 1 | Older instruction is a jump, call or conditional branch |
| a_prefix | input | 1 | Older instruction carries a prefix |
| a_disp | input | 1 | Older instruction has a displacement |
| a_imm | input | 1 | Older instruction has an immediate |
| a_dst | input | REG_IDX_W | Older destination register, 0 = none |
| a_src0 | input | REG_IDX_W | Older first source, 0 = none |
| a_src1 | input | REG_IDX_W | Older second source, 0 = none |
| b_valid | input | 1 | Younger descriptor present |
| b_simple | input | 1 | Younger instruction is simple |
| b_jump | input | 1 | Younger instruction is a control transfer |
| b_prefix | input | 1 | Younger instruction carries a prefix |
| b_disp | input | 1 | Younger instruction has a displacement |
| b_imm | input | 1 | Younger instruction has an immediate |
| b_dst | input | REG_IDX_W | Younger destination register, 0 = none |
| b_src0 | input | REG_IDX_W | Younger first source, 0 = none |
| b_src1 | input | REG_IDX_W | Younger second source, 0 = none |
| out_ready | input | 1 | Next stage accepts a new issue decision |
| u_valid | output | 1 | An instruction is issued to the u-pipe |
| v_valid | output | 1 | The younger instruction is issued to the v-pipe |
| consumed | output | 2 | Descriptors taken from the window (0, 1 or 2) |

## Verification
The assertions assume the descriptor fields are stable between clock edges. They also assume `rst` is held for at least one edge before any check that looks at the previous cycle. The stimulus changes inputs only on the falling edge and samples outputs on the following falling edge, so every decision is captured by exactly one rising edge. Register indices span the full 3-bit space, including 0. Because of this, the zero-register guard and every combination of RAW and WAW matches are exercised, rather than just a chosen few.

// File: rtl/pair_pkg.sv
package pair_pkg;

    parameter int unsigned REG_IDX_W = 3;
    localparam int unsigned SRC_N = 2;
    localparam int unsigned CNT_W = 2;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;
    localparam reg_idx_t NO_REG = '0;

    typedef struct packed {
        logic                 valid;
        logic                 simple;
        logic                 jump;
        logic                 prefix;
        logic                 has_disp;
        logic                 has_imm;
        reg_idx_t             dst;
        reg_idx_t [SRC_N-1:0] srcs;
    } slot_desc_t;

    typedef struct packed {
        logic             u_valid;
        logic             v_valid;
        logic [CNT_W-1:0] consumed;
    } issue_t;

    // a written register collides with a read one only if it names a real register
    function automatic logic reg_collides(reg_idx_t wr, reg_idx_t rd);
        return (wr != NO_REG) && (wr == rd);
    endfunction

    function automatic logic has_disp_and_imm(slot_desc_t d);
        return d.has_disp && d.has_imm;
    endfunction

endpackage

// File: rtl/pair_hazard_unit.sv
module pair_hazard_unit
    import pair_pkg::*;
(
    input  slot_desc_t older,
    input  slot_desc_t younger,
    output logic       raw_hit,
    output logic       waw_hit
);
    logic [SRC_N-1:0] src_hit;

    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        assign src_hit[s] = reg_collides(older.dst, younger.srcs[s]);
    end

    assign raw_hit = |src_hit;
    assign waw_hit = reg_collides(older.dst, younger.dst);

    always_comb begin
        // R8
        if (older.dst == NO_REG) begin
            zero_reg_no_hazard_chk: assert (!raw_hit && !waw_hit);
        end
    end
endmodule

// File: rtl/pair_rule_unit.sv
module pair_rule_unit
    import pair_pkg::*;
(
    input  slot_desc_t older,
    input  slot_desc_t younger,
    input  logic       raw_hit,
    input  logic       waw_hit,
    output logic       pair_ok
);
    logic form_ok;
    logic order_ok;
    logic hazard_free;

    assign form_ok     = older.simple && younger.simple
                       && !has_disp_and_imm(older) && !has_disp_and_imm(younger);
    assign order_ok    = !older.jump && !younger.prefix;
    assign hazard_free = !raw_hit && !waw_hit;
    assign pair_ok     = older.valid && younger.valid && form_ok && order_ok && hazard_free;

    always_comb begin
        // R3
        if (older.jump) begin
            jump_blocks_pair_chk: assert (!pair_ok);
        end
        // R7
        if (younger.prefix) begin
            prefix_v_pipe_chk: assert (!pair_ok);
        end
        // R2
        if (!older.simple || !younger.simple) begin
            simple_only_pair_chk: assert (!pair_ok);
        end
    end
endmodule

// File: rtl/issue_stage_reg.sv
module issue_stage_reg
    import pair_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ready,
    input  issue_t nxt,
    output issue_t cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (ready) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
    import pair_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 a_valid,
    input  logic                 a_simple,
    input  logic                 a_jump,
    input  logic                 a_prefix,
    input  logic                 a_disp,
    input  logic                 a_imm,
    input  logic [REG_IDX_W-1:0] a_dst,
    input  logic [REG_IDX_W-1:0] a_src0,
    input  logic [REG_IDX_W-1:0] a_src1,
    input  logic                 b_valid,
    input  logic                 b_simple,
    input  logic                 b_jump,
    input  logic                 b_prefix,
    input  logic                 b_disp,
    input  logic                 b_imm,
    input  logic [REG_IDX_W-1:0] b_dst,
    input  logic [REG_IDX_W-1:0] b_src0,
    input  logic [REG_IDX_W-1:0] b_src1,
    input  logic                 out_ready,
    output logic                 u_valid,
    output logic                 v_valid,
    output logic [1:0]           consumed
);
    slot_desc_t slot_a;
    slot_desc_t slot_b;
    logic       raw_hit;
    logic       waw_hit;
    logic       pair_ok;
    issue_t     nxt;
    issue_t     cur;

    always_comb begin
        slot_a = '{valid: a_valid, simple: a_simple, jump: a_jump, prefix: a_prefix,
                   has_disp: a_disp, has_imm: a_imm, dst: a_dst, srcs: {a_src1, a_src0}};
        slot_b = '{valid: b_valid, simple: b_simple, jump: b_jump, prefix: b_prefix,
                   has_disp: b_disp, has_imm: b_imm, dst: b_dst, srcs: {b_src1, b_src0}};
    end

    pair_hazard_unit i_hazard (
        .older   (slot_a),
        .younger (slot_b),
        .raw_hit (raw_hit),
        .waw_hit (waw_hit)
    );

    pair_rule_unit i_rules (
        .older   (slot_a),
        .younger (slot_b),
        .raw_hit (raw_hit),
        .waw_hit (waw_hit),
        .pair_ok (pair_ok)
    );

    always_comb begin
        nxt.u_valid  = slot_a.valid;
        nxt.v_valid  = pair_ok;
        nxt.consumed = !slot_a.valid ? CNT_W'(0) : (pair_ok ? CNT_W'(2) : CNT_W'(1));
    end

    issue_stage_reg i_issue (
        .clk   (clk),
        .rst   (rst),
        .ready (out_ready),
        .nxt   (nxt),
        .cur   (cur)
    );

    assign u_valid  = cur.u_valid;
    assign v_valid  = cur.v_valid;
    assign consumed = cur.consumed;

    // R10
    v_needs_u_chk: assert property (@(posedge clk) disable iff (rst)
        v_valid |-> u_valid);

    // R10
    consumed_count_chk: assert property (@(posedge clk) disable iff (rst)
        consumed == (u_valid ? (v_valid ? 2'd2 : 2'd1) : 2'd0));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !out_ready) |=> $stable({u_valid, v_valid, consumed}));

    // R12
    u_follows_a_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && out_ready) |=> (u_valid == $past(a_valid)));

    // R9
    single_when_b_absent_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && out_ready && !b_valid) |=> !v_valid);
endmodule

// File: tb/test_dual_issue_pair_check.sv
module test_dual_issue_pair_check;
    import pair_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_valid, a_simple, a_jump, a_prefix, a_disp, a_imm;
    logic b_valid, b_simple, b_jump, b_prefix, b_disp, b_imm;
    logic [REG_IDX_W-1:0] a_dst, a_src0, a_src1, b_dst, b_src0, b_src1;
    logic out_ready;
    logic u_valid, v_valid;
    logic [1:0] consumed;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_issue_pair_check i_dual_issue_pair_check (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_simple(a_simple), .a_jump(a_jump), .a_prefix(a_prefix),
        .a_disp(a_disp), .a_imm(a_imm), .a_dst(a_dst), .a_src0(a_src0), .a_src1(a_src1),
        .b_valid(b_valid), .b_simple(b_simple), .b_jump(b_jump), .b_prefix(b_prefix),
        .b_disp(b_disp), .b_imm(b_imm), .b_dst(b_dst), .b_src0(b_src0), .b_src1(b_src1),
        .out_ready(out_ready), .u_valid(u_valid), .v_valid(v_valid), .consumed(consumed)
    );

    function automatic logic model_pair();
        logic hz;
        hz = (a_dst != 0) && (a_dst == b_src0 || a_dst == b_src1 || a_dst == b_dst);
        return a_valid && b_valid && a_simple && b_simple && !a_jump
            && !(a_disp && a_imm) && !(b_disp && b_imm) && !b_prefix && !hz;
    endfunction

    function automatic string blame_tag();
        if (!a_valid || !b_valid) return "R9";
        if (!a_simple || !b_simple) return "R2";
        if (a_jump) return "R3";
        if ((a_disp && a_imm) || (b_disp && b_imm)) return "R6";
        if (b_prefix) return "R7";
        if (a_dst == 0) return "R8";
        if (a_dst == b_src0 || a_dst == b_src1) return "R4";
        if (a_dst == b_dst) return "R5";
        return "R12";
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {u,v,consumed} got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic clear_inputs();
        {a_valid, a_simple, a_jump, a_prefix, a_disp, a_imm} = '0;
        {b_valid, b_simple, b_jump, b_prefix, b_disp, b_imm} = '0;
        {a_dst, a_src0, a_src1, b_dst, b_src0, b_src1} = '0;
    endtask

    // one decision per cycle: drive at falling edge, sample at the next falling edge
    task automatic step_and_check(string tag);
        logic p;
        logic [3:0] exp;
        p = model_pair();
        exp = {a_valid, p, (!a_valid ? 2'd0 : (p ? 2'd2 : 2'd1))};
        @(posedge clk);
        @(negedge clk);
        check(tag, {u_valid, v_valid, consumed}, exp);
    endtask

    initial begin
        clear_inputs();
        out_ready = 1'b1;
        a_valid = 1'b1; b_valid = 1'b1; a_simple = 1'b1; b_simple = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {u_valid, v_valid, consumed}, 4'b0000);
        rst = 1'b0;
        clear_inputs();

        // R2 R3 R6 R7 R9: full sweep of flag bits with hazard-free registers
        for (int f = 0; f < 4096; f++) begin
            {a_valid, a_simple, a_jump, a_prefix, a_disp, a_imm,
             b_valid, b_simple, b_jump, b_prefix, b_disp, b_imm} = f[11:0];
            a_dst = 3'd1; a_src0 = 3'd2; a_src1 = 3'd3;
            b_dst = 3'd4; b_src0 = 3'd5; b_src1 = 3'd6;
            step_and_check(blame_tag());
        end

        // R4 R5 R8: full sweep of register indices with otherwise pairable flags
        clear_inputs();
        a_valid = 1'b1; a_simple = 1'b1; b_valid = 1'b1; b_simple = 1'b1;
        for (int r = 0; r < 4096; r++) begin
            {a_dst, b_dst, b_src0, b_src1} = r[11:0];
            a_src0 = b_dst; a_src1 = a_dst;
            step_and_check(blame_tag());
        end

        // R7: prefix on the older instruction only still pairs
        a_dst = 3'd1; b_dst = 3'd2; b_src0 = 3'd3; b_src1 = 3'd3;
        a_prefix = 1'b1;
        step_and_check("R7");

        // R11: stall holds a pair while inputs change
        a_prefix = 1'b0;
        step_and_check("R12");
        out_ready = 1'b0;
        a_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R11", {u_valid, v_valid, consumed}, 4'b1110);
        end
        out_ready = 1'b1;
        // R9: older absent, nothing issues
        step_and_check("R9");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule